// File: doc/BRIEF.md
# ADC Sample Format Converter

This block sits directly behind the ADC capture logic. Each clock it takes one raw converter sample of `IN_W` bits, with a valid strobe, and produces an output word widened to the next multiple of eight bits. Three static-style control bits steer the conversion:

- **enable** turns format handling on.
- **format type** says whether the incoming code is offset binary or two's complement.
- **sign-extend** asks for the padding bits to copy the sample's sign.

The result is registered once. The valid strobe is delayed by the same single cycle, so downstream logic sees a fixed one-cycle latency at full rate. The output can be used directly by DMA or processing stages that expect byte-aligned samples. Saturation, scaling and filtering are not part of this block.

Top module: `adc_fmt_conv`

## Requirements
- R1: While `rst_ni` is low, and on the first edge after its release with no valid input, `valid_o` is 0 and `sample_o` is all zeros.
- R2: `valid_o` equals `valid_i` delayed by exactly one clock. A sample presented with `valid_i` high appears on `sample_o` after the next rising edge.
- R3: With `fmt_en_i` = 0, the low `IN_W` bits of `sample_o` equal the raw sample and every bit above them is 0. `fmt_ob_i` and `fmt_sext_i` have no effect in this case.
- R4: With `fmt_en_i` = 1 and `fmt_ob_i` = 1 (offset binary), the sample's top bit (bit `IN_W-1`) is inverted, the other sample bits pass unchanged, and the padding bits are 0. `fmt_sext_i` has no effect in this case.
- R5: With `fmt_en_i` = 1, `fmt_ob_i` = 0 and `fmt_sext_i` = 1, every padding bit equals the sample's top bit (bit `IN_W-1`), and the low `IN_W` bits equal the raw sample.
- R6: With `fmt_en_i` = 1, `fmt_ob_i` = 0 and `fmt_sext_i` = 0, the low `IN_W` bits equal the raw sample and the padding bits are 0.
- R7: A cycle with `valid_i` = 0 leaves `sample_o` unchanged, whatever values are on `sample_i` and the control inputs.
- R8: `OUT_W` is `IN_W` rounded up to a multiple of 8, for `IN_W` from 8 to 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| sample_i | input | IN_W | Raw converter sample |
| fmt_en_i | input | 1 | Enable format handling |
| fmt_ob_i | input | 1 | 1 = input is offset binary, 0 = two's complement |
| fmt_sext_i | input | 1 | Sign-extend padding bits (two's-complement mode only) |
| valid_o | output | 1 | Output sample strobe |
| sample_o | output | OUT_W | Byte-aligned converted sample |

## Verification
The bench builds the block with `IN_W` = 12, which gives `OUT_W` = 16 and four padding bits. This width lets a test tell zero padding apart from sign padding, and it lets the inverted top bit be seen sitting just below the padding. Input codes at the two ends of the range (all zeros, all ones, the sign bit alone and its complement) exercise each mode. Each mode is also run with the two control bits it must ignore set to their opposite values.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  typedef enum logic [1:0] {
    MODE_RAW  = 2'd0,
    MODE_OB   = 2'd1,
    MODE_SEXT = 2'd2
  } fmt_mode_e;

  function automatic int byte_ceil(input int w);
    return ((w + 7) / 8) * 8;
  endfunction

endpackage

// File: rtl/adc_fmt_decode.sv
module adc_fmt_decode
  import adc_fmt_pkg::*;
(
  input  logic      en_i,
  input  logic      ob_i,
  input  logic      sext_i,
  output fmt_mode_e mode_o
);

  always_comb begin
    if (!en_i)      mode_o = MODE_RAW;
    else if (ob_i)  mode_o = MODE_OB;
    else if (sext_i) mode_o = MODE_SEXT;
    else            mode_o = MODE_RAW;
  end

  always_comb begin
    a_r5_sext_only_twos: assert (!(mode_o == MODE_SEXT) || (en_i && !ob_i && sext_i));
  end

endmodule

// File: rtl/adc_fmt_core.sv
module adc_fmt_core
  import adc_fmt_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = byte_ceil(IN_W)
) (
  input  logic [IN_W-1:0]  sample_i,
  input  fmt_mode_e        mode_i,
  output logic [OUT_W-1:0] word_o
);

  localparam int PAD_W = OUT_W - IN_W;
  localparam int MSB   = IN_W - 1;

  logic [IN_W-1:0] body;

  always_comb begin
    body = sample_i;
    if (mode_i == MODE_OB) body[MSB] = ~sample_i[MSB];
  end

  generate
    if (PAD_W > 0) begin : g_pad
      logic [PAD_W-1:0] pad;
      assign pad    = (mode_i == MODE_SEXT) ? {PAD_W{sample_i[MSB]}} : '0;
      assign word_o = {pad, body};
    end else begin : g_nopad
      assign word_o = body;
    end
  endgenerate

endmodule

// File: rtl/adc_fmt_reg.sv
module adc_fmt_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) q_o <= d_i;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r7_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(q_o));

endmodule

// File: rtl/adc_fmt_conv.sv
module adc_fmt_conv
  import adc_fmt_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = byte_ceil(IN_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  sample_i,
  input  logic             fmt_en_i,
  input  logic             fmt_ob_i,
  input  logic             fmt_sext_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] sample_o
);

  localparam int PAD_W = OUT_W - IN_W;
  localparam int MSB   = IN_W - 1;

  // R8: legal range and byte rounding
  initial begin
    a_r8_width_range: assert (IN_W >= 8 && IN_W <= 24);
    a_r8_out_width: assert (OUT_W % 8 == 0 && PAD_W >= 0 && PAD_W < 8);
  end

  fmt_mode_e        mode;
  logic [OUT_W-1:0] word;

  adc_fmt_decode u_dec (
    .en_i   (fmt_en_i),
    .ob_i   (fmt_ob_i),
    .sext_i (fmt_sext_i),
    .mode_o (mode)
  );

  adc_fmt_core #(.IN_W(IN_W), .OUT_W(OUT_W)) u_core (
    .sample_i (sample_i),
    .mode_i   (mode),
    .word_o   (word)
  );

  adc_fmt_reg #(.W(OUT_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .d_i     (word),
    .valid_o (valid_o),
    .q_o     (sample_o)
  );

  a_r3_raw_body: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fmt_en_i) |=> sample_o[MSB:0] == $past(sample_i));
  a_r4_ob_msb_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_en_i && fmt_ob_i) |=> sample_o[MSB] != $past(sample_i[MSB]));
  a_r6_twos_body: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_en_i && !fmt_ob_i) |=> sample_o[MSB:0] == $past(sample_i));

  generate
    if (PAD_W > 0) begin : g_pad_chk
      a_r5_pad_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && fmt_en_i && !fmt_ob_i && fmt_sext_i)
          |=> sample_o[OUT_W-1:IN_W] == {PAD_W{$past(sample_i[MSB])}});
      a_r3_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !(fmt_en_i && !fmt_ob_i && fmt_sext_i))
          |=> sample_o[OUT_W-1:IN_W] == '0);
    end
  endgenerate

endmodule

// File: tb/sim_adc_fmt_conv.sv
`timescale 1ns/1ps
module sim_adc_fmt_conv;

  localparam int IN_W  = 12;
  localparam int OUT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid_i = 1'b0;
  logic [IN_W-1:0]  sample_i = '0;
  logic             en = 1'b0, ob = 1'b0, sx = 1'b0;
  logic             valid_o;
  logic [OUT_W-1:0] sample_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_fmt_conv #(.IN_W(IN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sample_i(sample_i),
    .fmt_en_i(en), .fmt_ob_i(ob), .fmt_sext_i(sx),
    .valid_o(valid_o), .sample_o(sample_o)
  );

  function automatic logic [OUT_W-1:0] model(input logic [IN_W-1:0] s,
                                             input logic e, input logic o, input logic x);
    logic [IN_W-1:0] b;
    logic [3:0]      p;
    b = s;
    if (e && o) b[IN_W-1] = ~s[IN_W-1];
    p = (e && !o && x) ? {4{s[IN_W-1]}} : 4'h0;
    return {p, b};
  endfunction

  task automatic check(input string req, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [IN_W-1:0] s,
                       input logic e, input logic o, input logic x);
    @(negedge clk);
    valid_i = 1'b1; sample_i = s; en = e; ob = o; sx = x;
    @(posedge clk); #2;
    check("R2", {15'd0, valid_o}, 16'd1);
    check(req, sample_o, model(s, e, o, x));
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check("R1", {15'd0, valid_o}, 16'd0);
    check("R1", sample_o, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1", {15'd0, valid_o}, 16'd0);
    check("R1", sample_o, 16'h0000);
  endtask

  task automatic t_raw;
    apply("R3", 12'h800, 1'b0, 1'b0, 1'b0);
    apply("R3", 12'hFFF, 1'b0, 1'b0, 1'b0);
    apply("R3", 12'hABC, 1'b0, 1'b1, 1'b1);
    check("R3", sample_o, 16'h0ABC);
  endtask

  task automatic t_ob;
    apply("R4", 12'h000, 1'b1, 1'b1, 1'b0);
    apply("R4", 12'h800, 1'b1, 1'b1, 1'b0);
    apply("R4", 12'hFFF, 1'b1, 1'b1, 1'b1);
    check("R4", sample_o, 16'h07FF);
    apply("R4", 12'h123, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_sext;
    apply("R5", 12'h800, 1'b1, 1'b0, 1'b1);
    check("R5", sample_o, 16'hF800);
    apply("R5", 12'h7FF, 1'b1, 1'b0, 1'b1);
    apply("R5", 12'hABC, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_twos;
    apply("R6", 12'hABC, 1'b1, 1'b0, 1'b0);
    apply("R6", 12'hFFF, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    logic [OUT_W-1:0] last;
    apply("R7", 12'h5A5, 1'b1, 1'b0, 1'b1);
    last = sample_o;
    @(negedge clk);
    valid_i = 1'b0; sample_i = 12'hFFF; en = 1'b1; ob = 1'b1; sx = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R7", sample_o, last);
    check("R2", {15'd0, valid_o}, 16'd0);
  endtask

  initial begin
    t_reset();
    t_raw();
    t_ob();
    t_sext();
    t_twos();
    t_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule